// File: doc/BRIEF.md
# Physical Memory Protection CSR Bank

This block stores the per-entry configuration bytes and address registers of a physical memory protection unit, together with a small machine security register. A core reaches it through one CSR port: a write enable, a register kind, an index and a data word. Writes commit on the next clock edge. Reads are combinational from the same kind and index. The block also drives every raw configuration byte and address value onto flat buses for the region decoder and the access checker.

Every write passes a lock filter before it lands. The filter covers five cases: locks on individual entries, a lock held by a neighbour in top-of-range mode, a bypass bit that reopens locked configuration, a lockdown mode that rejects certain encodings, and sticky policy bits. The filter decides each configuration byte on its own, using the state from before the write.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset, every configuration byte, every address register and all three security bits read as zero, both on the export buses and through the read port.
- R2: Kind 0 selects a config CSR, kind 1 an address register, kind 2 the security register, and kind 3 nothing (it reads zero and ignores writes). Byte i of config CSR n (bits 8i+7:8i) belongs to entry 4n+i. A config byte has R at bit 0, W at bit 1, X at bit 2, the match mode at bits 4:3 (01 is top-of-range) and the lock at bit 7. An entry at or beyond NUM_ENTRIES reads zero, and writes to it are dropped.
- R3: When the bypass bit is clear, a config byte written to an entry whose lock bit is set is dropped. The other bytes of the same CSR are still judged on their own.
- R4: A write to an address register whose own entry is locked is dropped. The bypass bit does not change this.
- R5: A write to address register k is dropped when entry k+1 is locked and in top-of-range mode. If entry k+1 is locked in any other mode, the write is accepted. The highest entry has no neighbour to consult.
- R6: When the bypass bit is set, every config byte written to an implemented entry is accepted, whether or not that entry is locked and whether or not lockdown is set.
- R7: When lockdown is set and bypass is clear, a config byte that sets the lock bit but not X is dropped.
- R8: When lockdown is set and bypass is clear, a config byte with the lock bit clear and R/W/X equal to 3'b110 is dropped.
- R9: The security register has lockdown at bit 0, whitelist at bit 1 and bypass at bit 2. A write cannot raise bypass from 0 to 1 while any entry is locked. Bypass can always be cleared.
- R10: Once set, the lockdown and whitelist bits stay set until reset. A write of 0 leaves them at 1.
- R11: An accepted write shows on the export buses and on the read port one cycle after the edge that samples it. Reads need no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Write strobe for the selected register |
| csr_kind_i | input | 2 | Register kind: 0 config, 1 address, 2 security, 3 none |
| csr_idx_i | input | IDX_W | Config CSR number or address entry number |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data for kind and index |
| entry_cfg_o | output | NUM_ENTRIES*8 | Config byte of entry k at bits 8k+7:8k |
| entry_addr_o | output | NUM_ENTRIES*XLEN | Address register of entry k at slice k |
| sec_mml_o | output | 1 | Lockdown bit |
| sec_mmwp_o | output | 1 | Whitelist bit |
| sec_rlb_o | output | 1 | Lock-bypass bit |

## Verification
The bench builds the bank with six entries, a 32-bit word and a 4-bit index. With these values config CSR 1 holds two real entries and two missing ones, CSR 2 and above hold only missing entries, and address indices 6 to 15 fall out of range. Every cut-off rule is therefore reachable with few registers. The small state lets a bench model be compared against every exported byte and every readable register after each write. Five phases each start from reset with a different security setting and apply pseudo-random writes in which lock bits are rare, so that the accept and drop paths are both exercised many times.

// File: rtl/pmp_csr_pkg.sv
`timescale 1ns/1ps
package pmp_csr_pkg;
  localparam int CFG_BIT_R = 0;
  localparam int CFG_BIT_W = 1;
  localparam int CFG_BIT_X = 2;
  localparam int CFG_BIT_A = 3;
  localparam int CFG_BIT_L = 7;
  localparam logic [1:0] MATCH_TOR = 2'b01;
  localparam logic [2:0] RWX_SHARED = 3'b110;

  localparam int SEC_BIT_MML  = 0;
  localparam int SEC_BIT_MMWP = 1;
  localparam int SEC_BIT_RLB  = 2;

  // entries per config CSR step, independent of XLEN
  localparam int CFG_STRIDE = 4;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } csr_kind_e;
endpackage

// File: rtl/pmp_cfg_filter.sv
`timescale 1ns/1ps
module pmp_cfg_filter (
  input  logic       cur_lock_i,
  input  logic       new_lock_i,
  input  logic [2:0] new_rwx_i,
  input  logic       rlb_i,
  input  logic       mml_i,
  output logic       accept_o
);
  import pmp_csr_pkg::*;

  logic lock_no_x;
  logic shared_enc;

  assign lock_no_x  = new_lock_i && !new_rwx_i[CFG_BIT_X];
  assign shared_enc = !new_lock_i && (new_rwx_i == RWX_SHARED);
  assign accept_o   = rlb_i || (!cur_lock_i && (!mml_i || !(lock_no_x || shared_enc)));
endmodule

// File: rtl/pmp_entry.sv
`timescale 1ns/1ps
module pmp_entry #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_wdata_i,
  input  logic            addr_we_i,
  input  logic [XLEN-1:0] addr_wdata_i,
  input  logic            next_tor_lock_i,
  input  logic            rlb_i,
  input  logic            mml_i,
  output logic [7:0]      cfg_o,
  output logic [XLEN-1:0] addr_o
);
  import pmp_csr_pkg::*;

  logic [7:0]      cfg_q;
  logic [XLEN-1:0] addr_q;
  logic            cfg_ok;

  pmp_cfg_filter u_filter (
    .cur_lock_i (cfg_q[CFG_BIT_L]),
    .new_lock_i (cfg_wdata_i[CFG_BIT_L]),
    .new_rwx_i  (cfg_wdata_i[2:0]),
    .rlb_i      (rlb_i),
    .mml_i      (mml_i),
    .accept_o   (cfg_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_we_i && cfg_ok) cfg_q <= cfg_wdata_i;
      if (addr_we_i && !cfg_q[CFG_BIT_L] && !next_tor_lock_i) addr_q <= addr_wdata_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;

  assert_cfg_lock_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[CFG_BIT_L] && !rlb_i) |=> $stable(cfg_q));

  assert_addr_lock_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[CFG_BIT_L] |=> $stable(addr_q));

  assert_tor_guard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_tor_lock_i |=> $stable(addr_q));

  assert_bypass_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rlb_i && cfg_we_i) |=> (cfg_q == $past(cfg_wdata_i)));

  assert_lock_needs_x_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mml_i && !rlb_i && cfg_we_i && cfg_wdata_i[CFG_BIT_L] && !cfg_wdata_i[CFG_BIT_X])
    |=> $stable(cfg_q));

  assert_shared_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mml_i && !rlb_i && cfg_we_i && !cfg_wdata_i[CFG_BIT_L] && cfg_wdata_i[2:0] == RWX_SHARED)
    |=> $stable(cfg_q));
endmodule

// File: rtl/pmp_seccfg.sv
`timescale 1ns/1ps
module pmp_seccfg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] wdata_i,
  input  logic       any_locked_i,
  output logic       mml_o,
  output logic       mmwp_o,
  output logic       rlb_o
);
  import pmp_csr_pkg::*;

  logic mml_q, mmwp_q, rlb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mml_q  <= 1'b0;
      mmwp_q <= 1'b0;
      rlb_q  <= 1'b0;
    end else if (we_i) begin
      mml_q  <= mml_q  | wdata_i[SEC_BIT_MML];
      mmwp_q <= mmwp_q | wdata_i[SEC_BIT_MMWP];
      rlb_q  <= wdata_i[SEC_BIT_RLB] & (rlb_q | ~any_locked_i);
    end
  end

  assign mml_o  = mml_q;
  assign mmwp_o = mmwp_q;
  assign rlb_o  = rlb_q;

  assert_mml_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mml_q |=> mml_q);

  assert_mmwp_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmwp_q |=> mmwp_q);

  assert_rlb_no_raise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rlb_q && any_locked_i) |=> !rlb_q);
endmodule

// File: rtl/pmp_csr_bank.sv
`timescale 1ns/1ps
module pmp_csr_bank #(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        csr_we_i,
  input  logic [1:0]                  csr_kind_i,
  input  logic [IDX_W-1:0]            csr_idx_i,
  input  logic [XLEN-1:0]             csr_wdata_i,
  output logic [XLEN-1:0]             csr_rdata_o,
  output logic [NUM_ENTRIES*8-1:0]    entry_cfg_o,
  output logic [NUM_ENTRIES*XLEN-1:0] entry_addr_o,
  output logic                        sec_mml_o,
  output logic                        sec_mmwp_o,
  output logic                        sec_rlb_o
);
  import pmp_csr_pkg::*;

  localparam int BPC = XLEN / 8;

  logic [NUM_ENTRIES*8-1:0]    cfg_flat;
  logic [NUM_ENTRIES*XLEN-1:0] addr_flat;
  logic                        mml, mmwp, rlb;
  logic                        any_locked;
  logic                        sec_we;

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_entry
    logic       we_c;
    logic [7:0] byte_c;
    logic       we_a;
    logic       tor_lock;

    always_comb begin
      we_c   = 1'b0;
      byte_c = '0;
      if (csr_we_i && csr_kind_i == KIND_CFG) begin
        for (int i = 0; i < BPC; i++) begin
          if (int'(csr_idx_i) * CFG_STRIDE + i == k) begin
            we_c   = 1'b1;
            byte_c = csr_wdata_i[i*8 +: 8];
          end
        end
      end
    end

    assign we_a = csr_we_i && (csr_kind_i == KIND_ADDR) && (int'(csr_idx_i) == k);

    if (k + 1 < NUM_ENTRIES) begin : g_next
      assign tor_lock = cfg_flat[(k+1)*8 + CFG_BIT_L] &&
                        (cfg_flat[(k+1)*8 + CFG_BIT_A +: 2] == MATCH_TOR);
    end else begin : g_top
      assign tor_lock = 1'b0;
    end

    pmp_entry #(.XLEN(XLEN)) u_entry (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .cfg_we_i        (we_c),
      .cfg_wdata_i     (byte_c),
      .addr_we_i       (we_a),
      .addr_wdata_i    (csr_wdata_i),
      .next_tor_lock_i (tor_lock),
      .rlb_i           (rlb),
      .mml_i           (mml),
      .cfg_o           (cfg_flat[k*8 +: 8]),
      .addr_o          (addr_flat[k*XLEN +: XLEN])
    );
  end

  always_comb begin
    any_locked = 1'b0;
    for (int k = 0; k < NUM_ENTRIES; k++) any_locked |= cfg_flat[k*8 + CFG_BIT_L];
  end

  assign sec_we = csr_we_i && (csr_kind_i == KIND_SEC);

  pmp_seccfg u_sec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (sec_we),
    .wdata_i      (csr_wdata_i[2:0]),
    .any_locked_i (any_locked),
    .mml_o        (mml),
    .mmwp_o       (mmwp),
    .rlb_o        (rlb)
  );

  always_comb begin
    csr_rdata_o = '0;
    unique case (csr_kind_i)
      KIND_CFG: begin
        for (int k = 0; k < NUM_ENTRIES; k++)
          for (int i = 0; i < BPC; i++)
            if (int'(csr_idx_i) * CFG_STRIDE + i == k) csr_rdata_o[i*8 +: 8] = cfg_flat[k*8 +: 8];
      end
      KIND_ADDR: begin
        for (int k = 0; k < NUM_ENTRIES; k++)
          if (int'(csr_idx_i) == k) csr_rdata_o = addr_flat[k*XLEN +: XLEN];
      end
      KIND_SEC: begin
        csr_rdata_o[SEC_BIT_MML]  = mml;
        csr_rdata_o[SEC_BIT_MMWP] = mmwp;
        csr_rdata_o[SEC_BIT_RLB]  = rlb;
      end
      default: csr_rdata_o = '0;
    endcase
  end

  assign entry_cfg_o  = cfg_flat;
  assign entry_addr_o = addr_flat;
  assign sec_mml_o    = mml;
  assign sec_mmwp_o   = mmwp;
  assign sec_rlb_o    = rlb;

  assert_none_kind_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_kind_i == KIND_NONE) |-> (csr_rdata_o == '0));

  assert_write_lands_next_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_we_i) |=> ($stable(cfg_flat) && $stable(addr_flat)));
endmodule

// File: tb/sim_pmp_csr_bank.sv
`timescale 1ns/1ps
module sim_pmp_csr_bank;
  localparam int XLEN  = 32;
  localparam int NE    = 6;
  localparam int IDX_W = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we = 1'b0;
  logic [1:0]        kind = 2'd3;
  logic [IDX_W-1:0]  idx = '0;
  logic [XLEN-1:0]   wdata = '0;
  logic [XLEN-1:0]   rdata;
  logic [NE*8-1:0]   cfg_bus;
  logic [NE*XLEN-1:0] addr_bus;
  logic              s_mml, s_mmwp, s_rlb;

  always #10 clk = ~clk;

  pmp_csr_bank #(.XLEN(XLEN), .NUM_ENTRIES(NE), .IDX_W(IDX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(we), .csr_kind_i(kind), .csr_idx_i(idx),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .entry_cfg_o(cfg_bus), .entry_addr_o(addr_bus),
    .sec_mml_o(s_mml), .sec_mmwp_o(s_mmwp), .sec_rlb_o(s_rlb)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0]      mcfg [64];
  logic [XLEN-1:0] maddr [16];
  logic            m_mml, m_mmwp, m_rlb;
  logic [31:0]     rs = 32'h1d2c_3b4a;

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic cmp(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int e = 0; e < 64; e++) mcfg[e] = '0;
    for (int e = 0; e < 16; e++) maddr[e] = '0;
    m_mml = 1'b0; m_mmwp = 1'b0; m_rlb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = 1'b0; kind = 2'd3; rst_ni = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic cfg_ok(logic [7:0] old, logic [7:0] nv);
    logic bad;
    bad = (nv[7] && !nv[2]) || (!nv[7] && nv[2:0] == 3'b110);
    return m_rlb || (!old[7] && (!m_mml || !bad));
  endfunction

  task automatic wr(logic [1:0] k, int n, logic [XLEN-1:0] d);
    logic any_lock;
    @(negedge clk);
    we = 1'b1; kind = k; idx = IDX_W'(n); wdata = d;
    @(negedge clk);
    we = 1'b0;
    any_lock = 1'b0;
    for (int e = 0; e < NE; e++) any_lock |= mcfg[e][7];
    case (k)
      2'd0: for (int i = 0; i < XLEN/8; i++) begin
        int e;
        e = n * 4 + i;
        if (e < NE && cfg_ok(mcfg[e], d[i*8 +: 8])) mcfg[e] = d[i*8 +: 8];
      end
      2'd1: if (n < NE && !mcfg[n][7] &&
                !(n + 1 < NE && mcfg[n+1][7] && mcfg[n+1][4:3] == 2'b01)) maddr[n] = d;
      2'd2: begin
        m_mml  = m_mml | d[0];
        m_mmwp = m_mmwp | d[1];
        m_rlb  = d[2] && (m_rlb || !any_lock);
      end
      default: ;
    endcase
  endtask

  task automatic rd_chk(string tag, logic [1:0] k, int n, logic [XLEN-1:0] exp);
    @(negedge clk);
    kind = k; idx = IDX_W'(n);
    #2;
    cmp(tag, $sformatf("read kind%0d idx%0d", k, n), rdata, exp);
  endtask

  task automatic check_all(string tag);
    logic [XLEN-1:0] ev;
    for (int e = 0; e < NE; e++) begin
      cmp(tag, $sformatf("cfg bus entry%0d", e), XLEN'(cfg_bus[e*8 +: 8]), XLEN'(mcfg[e]));
      cmp(tag, $sformatf("addr bus entry%0d", e), addr_bus[e*XLEN +: XLEN], maddr[e]);
    end
    cmp(tag, "sec bits", XLEN'({s_rlb, s_mmwp, s_mml}), XLEN'({m_rlb, m_mmwp, m_mml}));
    for (int n = 0; n < 3; n++) begin
      for (int i = 0; i < 4; i++) ev[i*8 +: 8] = mcfg[n*4 + i];
      rd_chk(tag, 2'd0, n, ev);
    end
    for (int n = 0; n < 8; n++) rd_chk(tag, 2'd1, n, maddr[n]);
    rd_chk(tag, 2'd2, 0, XLEN'({m_rlb, m_mmwp, m_mml}));
    rd_chk(tag, 2'd3, 0, '0);
  endtask

  task automatic rand_phase(logic [2:0] sec, int ops);
    do_reset();
    if (sec != 0) wr(2'd2, 0, XLEN'(sec));
    for (int op = 0; op < ops; op++) begin
      logic [31:0] r, d;
      logic [1:0]  k;
      r = rnd();
      d = rnd();
      k = r[1:0];
      if (k == 2'd2 && r[12:9] != 0) k = 2'd0;
      if (k == 2'd0 && r[8:6] != 0) d = d & 32'h7f7f_7f7f;
      wr(k, (k == 2'd0) ? int'(r[3:2]) : int'(r[5:2]), d);
      check_all("R11");
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    check_all("R1");

    // packing, out-of-range entries and kind 3
    wr(2'd0, 0, 32'h1f0e_0d0c);  check_all("R2");
    wr(2'd0, 1, 32'hAABB_1122);  check_all("R2");
    wr(2'd0, 2, 32'h0102_0304);  check_all("R2");
    wr(2'd1, 9, 32'hdead_beef);  check_all("R2");
    wr(2'd3, 0, 32'hffff_ffff);  check_all("R2");
    wr(2'd1, 3, 32'h0000_1234);  check_all("R11");

    // bypass raised while nothing is locked, then reopens locked entry 1
    wr(2'd2, 0, 32'h4);          check_all("R9");
    wr(2'd0, 0, 32'h0000_8900);  check_all("R6");
    wr(2'd0, 0, 32'h0000_0b00);  check_all("R6");
    wr(2'd0, 0, 32'h9000_8900);  check_all("R6");
    wr(2'd2, 0, 32'h0);          check_all("R9");
    wr(2'd2, 0, 32'h4);          check_all("R9");

    wr(2'd0, 0, 32'h1103_0201);  check_all("R3");
    wr(2'd1, 1, 32'h5555_0000);  check_all("R4");
    wr(2'd1, 0, 32'h6666_0000);  check_all("R5");
    wr(2'd1, 2, 32'h7777_0000);  check_all("R5");
    wr(2'd1, 5, 32'h8888_0000);  check_all("R5");
    wr(2'd0, 1, 32'h0000_8d00);  check_all("R5");
    wr(2'd1, 4, 32'h9999_0000);  check_all("R5");
    wr(2'd1, 5, 32'haaaa_0000);  check_all("R4");

    // lockdown and whitelist set, then a clearing write
    wr(2'd2, 0, 32'h3);          check_all("R10");
    wr(2'd2, 0, 32'h0);          check_all("R10");
    wr(2'd0, 0, 32'h0000_0081);  check_all("R7");
    wr(2'd0, 0, 32'h0000_0085);  check_all("R7");
    wr(2'd0, 0, 32'h0006_0000);  check_all("R8");
    wr(2'd0, 0, 32'h0007_0000);  check_all("R8");
    wr(2'd0, 0, 32'h0086_0000);  check_all("R8");

    rand_phase(3'd0, 300);
    rand_phase(3'd4, 300);
    rand_phase(3'd1, 300);
    rand_phase(3'd5, 300);
    rand_phase(3'd2, 300);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule